// File: doc/BRIEF.md
# Carry-Chain Wide OR/NOR Gate

This block reduces a parameterised number of input bits to one output bit, producing either their OR or their NOR; a parameter fixes which one at elaboration. It is purely combinational: there is no clock, no reset and no handshake. A wide gate is built the way a LUT-plus-carry fabric would build it. The inputs are cut into groups of four, starting at bit 0. Each group feeds a small lookup that flags "this group is all zero". That flag steers one stage of a chain of carry multiplexers.

A stage whose group is all zero passes the result of the stages below it. A stage whose group holds any set bit forces the chain to the asserted level. The OR and NOR polarities differ only in two tied constants: the value placed on every stage's local data input, and the value fed into the bottom of the chain. The top stage's output is the gate output. When the gate has four inputs or fewer, the chain is skipped and one lookup computes the result directly.

Top module: `carry_chain_wide_or`

## Requirements
- R1: With IS_NOR = 0, `y_o` equals the OR of all N bits of `in_i` for every input vector.
- R2: With IS_NOR = 1, `y_o` equals the inverse of the OR of all N bits of `in_i` for every input vector.
- R3: For N > 4, bits are grouped four at a time from bit 0 upward. There are floor((N-1)/4) full groups, and the top group takes the remaining 1 to 4 bits. Each group's lookup outputs 1 exactly when all of its bits are 0.
- R4: Each chain stage passes its carry-in when its group lookup is 1. When the lookup is 0, it outputs the asserted level, which is 1 for OR and 0 for NOR. A set bit confined to the lowest group therefore reaches `y_o` through every stage above it.
- R5: The bottom carry-in is the deasserted level (0 for OR, 1 for NOR), so an all-zero input gives the deasserted level at `y_o`.
- R6: A single set bit at any position, including the only bit of a one-bit top group and bit N-1, drives `y_o` to the asserted level.
- R7: For N of 4 or fewer, one lookup of N inputs produces `y_o` directly. It still follows R1 or R2 for all 2^N input vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | N | Bits to be reduced; bit 0 belongs to the lowest group |
| y_o | output | 1 | Reduced result: OR when IS_NOR = 0, NOR when IS_NOR = 1 |

## Verification
The bound checker examines every input change. It confirms that the output matches the chosen reduction. It confirms that each group flag is high exactly when its bits are zero, that each stage either passes its carry-in or drives the asserted level as its flag dictates, and that an all-zero input leaves the output deasserted. What only the bench scenarios can show is that the structure holds across shapes: top groups of one, two, three and four bits, the single-lookup variant, and both polarities. It also shows that a set bit in the lowest group truly propagates through the whole chain to the port.

// File: rtl/wor_pkg.sv
package wor_pkg;

   // Lookup width of one chain stage.
   localparam int GROUP_W = 4;

   // Number of complete four-bit groups below the top group.
   function automatic int full_groups(input int n);
      return (n > GROUP_W) ? (n - 1) / GROUP_W : 0;
   endfunction

   // Width of the top (possibly partial) group.
   function automatic int top_width(input int n);
      return n - GROUP_W * full_groups(n);
   endfunction

   // Truth table that is 1 only when every lookup input is 0.
   function automatic logic [15:0] zero_table(input int k);
      logic [15:0] t;
      t = '0;
      if (k >= 1) t[0] = 1'b1;
      return t;
   endfunction

   // Truth table that is 1 whenever any of the k lookup inputs is 1.
   function automatic logic [15:0] any_table(input int k);
      logic [15:0] t;
      t = '0;
      for (int i = 1; i < (1 << k); i++) t[i] = 1'b1;
      return t;
   endfunction

endpackage

// File: rtl/wor_lut.sv
module wor_lut #(
   parameter int                   K     = 4,
   parameter logic [(1<<K)-1:0]    TABLE = '0
) (
   input  logic [K-1:0] a_i,
   output logic         f_o
);

   generate
      if (K < 1 || K > 4) begin : g_bad_k
         $error("wor_lut: K must be 1..4");
      end

      if (K == 1 && TABLE == 2'b01) begin : g_inv
         // A one-input zero detect is a plain inverter.
         assign f_o = ~a_i[0];
      end else begin : g_table
         assign f_o = TABLE[a_i];
      end
   endgenerate

endmodule

// File: rtl/wor_cmux.sv
module wor_cmux (
   input  logic sel_i,
   input  logic ci_i,
   input  logic di_i,
   output logic co_o
);

   // Select high propagates the chain, select low injects local data.
   assign co_o = sel_i ? ci_i : di_i;

endmodule

// File: rtl/carry_chain_wide_or.sv
module carry_chain_wide_or #(
   parameter int N      = 12,
   parameter bit IS_NOR = 1'b0
) (
   input  logic [N-1:0] in_i,
   output logic         y_o
);
   import wor_pkg::*;

   localparam int   FULL       = full_groups(N);
   localparam int   TOPW       = top_width(N);
   localparam int   NS         = FULL + 1;
   localparam logic ASSERTED   = IS_NOR ? 1'b0 : 1'b1;
   localparam logic DEASSERTED = ~ASSERTED;
   localparam logic [15:0] ZT  = zero_table(TOPW);
   localparam logic [15:0] GZT = zero_table(GROUP_W);
   localparam logic [15:0] OT  = IS_NOR ? zero_table(TOPW) : any_table(TOPW);

   logic [NS-1:0] sel_w;
   logic [NS-1:0] cin_w;
   logic [NS-1:0] cout_w;

   generate
      if (N < 1) begin : g_bad_n
         $error("carry_chain_wide_or: N must be at least 1");
      end

      if (N <= GROUP_W) begin : g_single
         // Narrow gate: one lookup holds the whole function.
         wor_lut #(.K(N), .TABLE(OT[(1<<N)-1:0])) u_lut (
            .a_i (in_i),
            .f_o (y_o)
         );
         assign sel_w  = '0;
         assign cin_w  = '0;
         assign cout_w = '0;
      end else begin : g_chain
         for (genvar g = 0; g < FULL; g++) begin : g_grp
            wor_lut #(.K(GROUP_W), .TABLE(GZT)) u_zd (
               .a_i (in_i[GROUP_W*g +: GROUP_W]),
               .f_o (sel_w[g])
            );
         end

         wor_lut #(.K(TOPW), .TABLE(ZT[(1<<TOPW)-1:0])) u_top_zd (
            .a_i (in_i[GROUP_W*FULL +: TOPW]),
            .f_o (sel_w[FULL])
         );

         for (genvar s = 0; s < NS; s++) begin : g_stage
            if (s == 0) begin : g_first
               assign cin_w[s] = DEASSERTED;
            end else begin : g_link
               assign cin_w[s] = cout_w[s-1];
            end
            wor_cmux u_mux (
               .sel_i (sel_w[s]),
               .ci_i  (cin_w[s]),
               .di_i  (ASSERTED),
               .co_o  (cout_w[s])
            );
         end

         assign y_o = cout_w[NS-1];
      end
   endgenerate

endmodule

// File: rtl/wor_checker.sv
module wor_checker #(
   parameter int N      = 12,
   parameter bit IS_NOR = 1'b0,
   parameter int NS     = 1
) (
   input logic [N-1:0]  in_i,
   input logic          y_o,
   input logic [NS-1:0] sel_w,
   input logic [NS-1:0] cin_w,
   input logic [NS-1:0] cout_w
);
   localparam logic ASSERTED = IS_NOR ? 1'b0 : 1'b1;

   always_comb begin
      if (!IS_NOR) begin
         assert_or_value_R1: assert (y_o == (|in_i))
            else $error("R1 OR output mismatch");
      end else begin
         assert_nor_value_R2: assert (y_o == ~(|in_i))
            else $error("R2 NOR output mismatch");
      end

      assert_idle_level_R5: assert ((|in_i) || (y_o == ~ASSERTED))
         else $error("R5 all-zero input not deasserted");

      if (N <= 4) begin
         assert_single_lookup_R7: assert (y_o == (IS_NOR ? ~(|in_i) : (|in_i)))
            else $error("R7 single lookup mismatch");
      end else begin
         for (int g = 0; g < NS; g++) begin
            logic any_set;
            any_set = 1'b0;
            for (int b = 4*g; b < 4*g + 4; b++) begin
               if (b < N) any_set = any_set | in_i[b];
            end
            assert_group_flag_R3: assert (sel_w[g] == !any_set)
               else $error("R3 group flag wrong for group %0d", g);
            assert_stage_pass_R4: assert (!sel_w[g] || (cout_w[g] == cin_w[g]))
               else $error("R4 stage %0d did not propagate", g);
            assert_stage_local_R4: assert (sel_w[g] || (cout_w[g] == ASSERTED))
               else $error("R4 stage %0d did not assert", g);
         end
      end
   end

endmodule

bind carry_chain_wide_or wor_checker #(.N(N), .IS_NOR(IS_NOR), .NS(NS)) u_chk (
   .in_i   (in_i),
   .y_o    (y_o),
   .sel_w  (sel_w),
   .cin_w  (cin_w),
   .cout_w (cout_w)
);

// File: tb/carry_chain_wide_or_test.sv
module carry_chain_wide_or_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int fails  = 0;
   logic [15:0] stim = '0;

   // Shapes: top groups of 4 (N=12), 1 (N=5), 2 (N=6), 3 (N=7); narrow N=3, N=4.
   logic y12, y5, y6, y7, y3, y4;

   carry_chain_wide_or #(.N(12), .IS_NOR(1'b0)) uut    (.in_i(stim[11:0]), .y_o(y12));
   carry_chain_wide_or #(.N(5),  .IS_NOR(1'b1)) u_n5   (.in_i(stim[4:0]),  .y_o(y5));
   carry_chain_wide_or #(.N(6),  .IS_NOR(1'b0)) u_n6   (.in_i(stim[5:0]),  .y_o(y6));
   carry_chain_wide_or #(.N(7),  .IS_NOR(1'b1)) u_n7   (.in_i(stim[6:0]),  .y_o(y7));
   carry_chain_wide_or #(.N(3),  .IS_NOR(1'b0)) u_n3   (.in_i(stim[2:0]),  .y_o(y3));
   carry_chain_wide_or #(.N(4),  .IS_NOR(1'b1)) u_n4   (.in_i(stim[3:0]),  .y_o(y4));

   function automatic logic expect_out(input logic [15:0] v, input int n, input bit nor_mode);
      logic r;
      r = 1'b0;
      for (int i = 0; i < n; i++) r = r | v[i];
      return nor_mode ? ~r : r;
   endfunction

   task automatic check1(input logic act, input logic exp, input string req, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s stim=%h actual=%b expected=%b", req, tag, stim, act, exp);
      end
   endtask

   // Apply stim and compare every instance against its expected value.
   task automatic apply_and_check(input logic [15:0] v, input string req);
      @(negedge clk);
      stim = v;
      #5;
      check1(y12, expect_out(v, 12, 1'b0), req, "N12_OR");
      check1(y5,  expect_out(v, 5,  1'b1), req, "N5_NOR");
      check1(y6,  expect_out(v, 6,  1'b0), req, "N6_OR");
      check1(y7,  expect_out(v, 7,  1'b1), req, "N7_NOR");
      check1(y3,  expect_out(v, 3,  1'b0), req, "N3_OR");
      check1(y4,  expect_out(v, 4,  1'b1), req, "N4_NOR");
   endtask

   task automatic t_all_zero;
      // R5: all-zero gives 0 for OR instances, 1 for NOR instances.
      apply_and_check(16'h0000, "R5");
   endtask

   task automatic t_single_hot;
      // R6 and R3: each bit alone, through every group including top groups.
      for (int i = 0; i < 12; i++) apply_and_check(16'h1 << i, "R6");
      apply_and_check(16'h0800, "R3");   // only bit of N12 top group end
      apply_and_check(16'h0010, "R3");   // N5 one-bit top group
   endtask

   task automatic t_all_ones;
      apply_and_check(16'hFFFF, "R1");
      apply_and_check(16'h0FFF, "R2");
   endtask

   task automatic t_low_group_propagate;
      // R4: set bits confined to group 0 must travel through all upper stages.
      for (int i = 1; i < 16; i++) apply_and_check(16'(i), "R4");
   endtask

   task automatic t_narrow_exhaustive;
      // R7: every 4-bit pattern on the single-lookup instances.
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         stim = 16'(i);
         #5;
         check1(y3, expect_out(stim, 3, 1'b0), "R7", "N3_OR");
         check1(y4, expect_out(stim, 4, 1'b1), "R7", "N4_NOR");
      end
   endtask

   task automatic t_random;
      for (int k = 0; k < 300; k++) begin
         logic [15:0] v;
         v = 16'($urandom);
         if (k % 3 == 0) v = v & (16'h1 << ($urandom % 16));
         apply_and_check(v, (k % 2 == 0) ? "R1" : "R2");
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1;
      // Initial state: all inputs zero.
      check1(y12, 1'b0, "R5", "init_N12_OR");
      check1(y5,  1'b1, "R5", "init_N5_NOR");
      t_all_zero();
      t_single_hot();
      t_all_ones();
      t_low_group_propagate();
      t_narrow_exhaustive();
      t_random();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule